// File: doc/BRIEF.md
# Cartridge RAM Mapper Control Logic

This block is the RAM-enable portion of a console cartridge mapper. It watches a 16-bit processor bus with active-low memory request, I/O request, read and write strobes. From it the block drives one active-low chip select for each of four devices: the cartridge ROM, the lower half of the cartridge SRAM, the upper half of the cartridge SRAM, and the console's internal work RAM.

Two byte registers set how the memory map is shared out:

- A mapper control register, loaded by a memory write to 0xFFFC.
- A console memory-control register, loaded by an I/O write to port 0x3E.

Cartridge SRAM may take over the top 16K window only after the console's internal RAM has been switched off through the I/O register. This rule keeps the two RAMs from ever answering the same access. Software can therefore choose between two layouts:

- 24K: cartridge RAM from 0x8000 plus the internal RAM, by writing 0x08 to 0xFFFC.
- 32K of cartridge RAM: by writing 0xBB to port 0x3E and 0x1C to 0xFFFC.

Top module: `cart_ram_mapper`

## Requirements
- R1: After reset both registers are zero. Both cartridge SRAM selects are then inactive, and the work RAM select follows accesses in 0xC000-0xFFFF.
- R2: rom_cs_n is low exactly when mreq_n is low and the address is in 0x0000-0x7FFF. While mreq_n is high, all four selects are high.
- R3: Bit 3 of the mapper control register enables sram_lo_cs_n for memory accesses in 0x8000-0xBFFF.
- R4: sram_hi_cs_n is low for a memory access in 0xC000-0xFFFF only when mapper control bit 4 is set and memory-control bit 4 is also set.
- R5: The work RAM select covers 0xC000-0xFFFF, so its 8K contents repeat every 8K in that window. Setting bit 4 of the memory-control register stops the work RAM from being selected.
- R6: At most one of the four selects is low in any cycle.
- R7: A memory write to 0xFFFC loads the data byte into the mapper control register at the clock edge of the write. During that same cycle the access still selects the device that the old settings map at 0xFFFC.
- R8: The SRAM address-bit output is 1 while the upper SRAM half is selected and 0 while the lower half is selected.
- R9: None of the following changes either register:
  - a read at 0xFFFC or at the port,
  - a memory write elsewhere,
  - an I/O write to another port.

  The memory-control register matches on the low 8 address bits only, so port 0x3E is decoded as 0x??3E.
- R10: The settings 0x08 to 0xFFFC with the port left at zero give SRAM at 0x8000-0xBFFF plus work RAM at 0xC000-0xFFFF. The settings 0xBB to the port and 0x1C to 0xFFFC give SRAM in both windows and no work RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| bus_data | input | 8 | Processor write data |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_cs_n | output | 1 | Cartridge ROM select |
| sram_lo_cs_n | output | 1 | Cartridge SRAM lower-half select (0x8000 window) |
| sram_hi_cs_n | output | 1 | Cartridge SRAM upper-half select (0xC000 window) |
| wram_cs_n | output | 1 | Internal work RAM select |
| sram_a14 | output | 1 | Cartridge SRAM half-select address bit |

## Verification
The hardest state to reach is the upper SRAM window being enabled in the mapper register while the work RAM is still on. From the ports this state looks exactly like the reset state, so it must be created deliberately. The bench writes 0x10 and 0x1C to 0xFFFC without touching the port, and checks that only the work RAM answers in 0xC000-0xFFFF. It then sets the port and sweeps the window again. The same-cycle rule for writes at 0xFFFC is checked by sampling the selects while the write strobe is still low, before the register has loaded, under both the old layout and the new one.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

   // Active-high view of the four device selects
   typedef struct packed {
      logic rom;
      logic sram_lo;
      logic sram_hi;
      logic wram;
   } map_sel_t;

   // Window codes taken from the two top address bits
   typedef enum logic [1:0] {
      WIN_ROM0 = 2'b00,
      WIN_ROM1 = 2'b01,
      WIN_LOW  = 2'b10,
      WIN_HIGH = 2'b11
   } map_win_e;

endpackage

// File: rtl/cart_map_regs.sv
module cart_map_regs #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned IO_MATCH_W  = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFFC,
   parameter logic [ADDR_W-1:0] IO_PORT   = 16'h003E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              mreq_n,
   input  logic              iorq_n,
   input  logic              wr_n,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] memctl_q
);

   localparam int unsigned IO_HI = IO_MATCH_W - 1;

   logic ctrl_hit;
   logic port_hit;
   logic ctrl_wr;
   logic port_wr;

   if (IO_MATCH_W == 0 || IO_MATCH_W > ADDR_W) begin : g_bad_io_w
      $error("IO_MATCH_W must be between 1 and ADDR_W");
   end

   assign ctrl_hit = (bus_addr == CTRL_ADDR);

   // Port decode: either the full address or only its low bits
   if (IO_MATCH_W == ADDR_W) begin : g_io_full
      assign port_hit = (bus_addr == IO_PORT);
   end else begin : g_io_part
      assign port_hit = (bus_addr[IO_HI:0] == IO_PORT[IO_HI:0]);
   end

   assign ctrl_wr = !mreq_n && !wr_n && ctrl_hit;
   assign port_wr = !iorq_n && mreq_n && !wr_n && port_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= bus_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         memctl_q <= '0;
      end else if (port_wr) begin
         memctl_q <= bus_data;
      end
   end

   // R7: mapper register takes the written byte
   a_r7_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n && !wr_n && bus_addr == CTRL_ADDR) |=> (ctrl_q == $past(bus_data)));

   // R9: no write strobe means no change
   a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_n || mreq_n) |=> $stable(ctrl_q));

   a_r9_memctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_n || iorq_n) |=> $stable(memctl_q));

endmodule

// File: rtl/cart_map_decode.sv
module cart_map_decode
   import cart_map_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              mreq_n,
   input  logic              lo_en,
   input  logic              hi_en,
   input  logic              wram_dis,
   output map_sel_t          sel,
   output logic              sram_half
);

   localparam int unsigned TOP = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("ADDR_W must be at least 2");
   end

   map_win_e win;

   assign win = map_win_e'(bus_addr[TOP -: 2]);

   always_comb begin
      sel = '0;
      if (!mreq_n) begin
         unique case (win)
            WIN_ROM0, WIN_ROM1: sel.rom = 1'b1;
            WIN_LOW:  sel.sram_lo = lo_en;
            WIN_HIGH: begin
               // Cartridge RAM here only once the internal RAM is off
               sel.sram_hi = hi_en && wram_dis;
               sel.wram    = !wram_dis;
            end
            default: sel = '0;
         endcase
      end
   end

   assign sram_half = (win == WIN_HIGH);

endmodule

// File: rtl/cart_ram_mapper.sv
module cart_ram_mapper
   import cart_map_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned IO_MATCH_W   = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFFC,
   parameter logic [ADDR_W-1:0] IO_PORT   = 16'h003E,
   parameter int unsigned LO_EN_BIT    = 3,
   parameter int unsigned HI_EN_BIT    = 4,
   parameter int unsigned WRAM_DIS_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       bus_addr,
   input  logic [7:0]        bus_data,
   input  logic              mreq_n,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic              rom_cs_n,
   output logic              sram_lo_cs_n,
   output logic              sram_hi_cs_n,
   output logic              wram_cs_n,
   output logic              sram_a14
);

   if (ADDR_W != 16 || DATA_W != 8) begin : g_bad_bus
      $error("Bus ports are fixed at 16 address and 8 data bits");
   end
   if (LO_EN_BIT >= DATA_W || HI_EN_BIT >= DATA_W || WRAM_DIS_BIT >= DATA_W) begin : g_bad_bit
      $error("Enable bit index outside the data byte");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] memctl_q;
   map_sel_t          sel;
   logic              half;
   logic              rd_unused;

   assign rd_unused = rd_n;

   cart_map_regs #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .IO_MATCH_W (IO_MATCH_W),
      .CTRL_ADDR  (CTRL_ADDR),
      .IO_PORT    (IO_PORT)
   ) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_data (bus_data),
      .mreq_n   (mreq_n),
      .iorq_n   (iorq_n),
      .wr_n     (wr_n),
      .ctrl_q   (ctrl_q),
      .memctl_q (memctl_q)
   );

   cart_map_decode #(
      .ADDR_W (ADDR_W)
   ) dec_i (
      .bus_addr  (bus_addr),
      .mreq_n    (mreq_n),
      .lo_en     (ctrl_q[LO_EN_BIT]),
      .hi_en     (ctrl_q[HI_EN_BIT]),
      .wram_dis  (memctl_q[WRAM_DIS_BIT]),
      .sel       (sel),
      .sram_half (half)
   );

   assign rom_cs_n     = !sel.rom;
   assign sram_lo_cs_n = !sel.sram_lo;
   assign sram_hi_cs_n = !sel.sram_hi;
   assign wram_cs_n    = !sel.wram;
   assign sram_a14     = half;

   // R6: never two devices at once
   a_r6_one_device: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!rom_cs_n, !sram_lo_cs_n, !sram_hi_cs_n, !wram_cs_n}) <= 1);

   // R2: ROM only in the lower 32K under a memory request
   a_r2_rom_window: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_cs_n |-> (!mreq_n && !bus_addr[15]));

   // R4: upper SRAM only once the work RAM is disabled
   a_r4_hi_guard: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_hi_cs_n |-> (memctl_q[WRAM_DIS_BIT] && ctrl_q[HI_EN_BIT]));

   // R5: a disabled work RAM stays deselected
   a_r5_wram_off: assert property (@(posedge clk) disable iff (!rst_n)
      memctl_q[WRAM_DIS_BIT] |-> wram_cs_n);

   // R8: SRAM half bit follows the selected window
   a_r8_half_hi: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_hi_cs_n |-> sram_a14);

   a_r8_half_lo: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_lo_cs_n |-> !sram_a14);

endmodule

// File: tb/cart_ram_mapper_tb_top.sv
`timescale 1ns/1ps
module cart_ram_mapper_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_data = '0;
   logic        mreq_n = 1'b1;
   logic        iorq_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        rom_cs_n, sram_lo_cs_n, sram_hi_cs_n, wram_cs_n, sram_a14;

   int checks = 0;
   int failures = 0;
   logic [7:0] m_ctrl = '0;
   logic [7:0] m_port = '0;

   always #2.5 clk = !clk;

   cart_ram_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
      .rom_cs_n(rom_cs_n), .sram_lo_cs_n(sram_lo_cs_n),
      .sram_hi_cs_n(sram_hi_cs_n), .wram_cs_n(wram_cs_n), .sram_a14(sram_a14)
   );

   // Expected active-high selects {rom, lo, hi, wram}
   function automatic logic [3:0] exp_sel(input logic [15:0] a, input logic mq,
                                          input logic [7:0] c, input logic [7:0] p);
      logic [3:0] r;
      r = 4'b0000;
      if (!mq) begin
         if (a < 16'h8000) r[3] = 1'b1;
         else if (a < 16'hC000) r[2] = c[3];
         else begin
            r[1] = c[4] && p[4];
            r[0] = !p[4];
         end
      end
      return r;
   endfunction

   task automatic check_sel(input string req, input logic [3:0] exp);
      logic [3:0] act;
      act = {!rom_cs_n, !sram_lo_cs_n, !sram_hi_cs_n, !wram_cs_n};
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s addr=%h act=%b exp=%b", req, bus_addr, act, exp);
      end
      if (act[2] || act[1]) begin
         checks++;
         if (sram_a14 !== act[1]) begin
            failures++;
            $display("FAIL R8 addr=%h act=%b exp=%b", bus_addr, sram_a14, act[1]);
         end
      end
   endtask

   // Read sweep over the whole map, 64 points plus an idle point
   task automatic sweep(input string req);
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         bus_addr = 16'(i * 1024 + ((i % 3) * 16'h1F1));
         mreq_n = 1'b0; rd_n = 1'b0;
         #1 check_sel(req, exp_sel(bus_addr, 1'b0, m_ctrl, m_port));
      end
      @(negedge clk);
      mreq_n = 1'b1; rd_n = 1'b1; bus_addr = 16'hC123;
      #1 check_sel("R2", 4'b0000);
   endtask

   task automatic mem_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_data = d; mreq_n = 1'b0; wr_n = 1'b0;
      // R7: during the write, selection follows the old settings
      #1 check_sel("R7", exp_sel(a, 1'b0, m_ctrl, m_port));
      @(negedge clk);
      mreq_n = 1'b1; wr_n = 1'b1;
      if (a == 16'hFFFC) m_ctrl = d;
   endtask

   task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_data = d; iorq_n = 1'b0; wr_n = 1'b0;
      #1 check_sel("R9", 4'b0000);
      @(negedge clk);
      iorq_n = 1'b1; wr_n = 1'b1;
      if (a[7:0] == 8'h3E) m_port = d;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      sweep("R1");

      // R3: lower SRAM window
      mem_wr(16'hFFFC, 8'h08);
      sweep("R3");
      // R10: 24K layout, then same-cycle check of a write into work RAM
      mem_wr(16'hFFFC, 8'h08);
      sweep("R10");

      // R4: upper enable without port bit keeps work RAM
      mem_wr(16'hFFFC, 8'h10);
      sweep("R4");
      mem_wr(16'hFFFC, 8'h1C);
      sweep("R4");

      // R9: reads and stray writes do not load registers
      @(negedge clk);
      bus_addr = 16'hFFFC; bus_data = 8'h00; mreq_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      mreq_n = 1'b1; rd_n = 1'b1;
      mem_wr(16'hFFFD, 8'h00);
      mem_wr(16'h7FFC, 8'h00);
      io_wr(16'h003F, 8'hFF);
      @(negedge clk);
      bus_addr = 16'h003E; bus_data = 8'hFF; iorq_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      iorq_n = 1'b1; rd_n = 1'b1;
      sweep("R9");

      // R5: port bit 4 disables work RAM, upper SRAM takes over
      io_wr(16'h123E, 8'h10);
      sweep("R5");
      // R10: 32K cartridge RAM layout
      io_wr(16'h003E, 8'hBB);
      mem_wr(16'hFFFC, 8'h1C);
      sweep("R10");
      // R7: write at 0xFFFC lands in upper SRAM while turning it off
      mem_wr(16'hFFFC, 8'h08);
      sweep("R7");
      // R5: work RAM off with upper SRAM off leaves the window empty
      sweep("R5");

      // R1: reset clears both registers
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_ctrl = '0; m_port = '0;
      sweep("R1");
      // R6 is covered by every exact one-hot comparison above

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #500000;
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule